// File: doc/BRIEF.md
# Program Memory Fetch Mode Router

This block sits between a processor core's instruction fetch stage and the two places instructions can live: an on-chip flash and an external memory bus. It holds a 21-bit byte-addressed program counter covering a 2-Mbyte space. It issues one fetch at a time and sends each fetch to the on-chip port, to the external port, or to neither. The choice comes from a 2-bit memory mode and the on-chip flash size. When neither memory backs an address, the block returns an all-zero word, which the core executes as a no-op.

The core raises `fetch_en` to request words. It can redirect the counter with a branch target or with one of two interrupt vector requests. Each memory port is a request/acknowledge pair. The request and its address stay stable until the port acknowledges. The returned word is presented on `instr_word` together with its address and a one-cycle valid pulse. The mode is loaded through a small write strobe and resets to on-chip-only. The flash size is a parameter: `FLASH_KB` = 64 gives a top address of 0x0FFFF, and 128 gives 0x1FFFF.

Top module: `fetch_route_top`

## Requirements
- R1: After reset `pc_out` is 0x000000, neither `int_req` nor `ext_req` is high, `instr_valid` is low, and the mode is on-chip-only (code 2'b11).
- R2: A cycle with `cfg_we` high loads `cfg_mode` as the new mode, with codes 2'b00 external-only, 2'b01 extended, 2'b10 boot-block and 2'b11 on-chip-only; the new mode governs later fetches.
- R3: In external-only mode every fetch raises `ext_req` and never `int_req`, whatever the address.
- R4: In boot-block mode a fetch at byte address 0x000000..0x0001FF uses the on-chip port, and any higher address uses the external port.
- R5: In on-chip-only mode a fetch at or below the flash top uses the on-chip port; above it no strobe is raised and the delivered word is 16'h0000.
- R6: In extended mode a fetch at or below the flash top uses the on-chip port, and any address above it up to 0x1FFFFE uses the external port.
- R7: The two request strobes are never high together. A strobe stays high with a stable address until its port acknowledges, and that address equals the program counter at the time the fetch was accepted.
- R8: `instr_valid` pulses for exactly the cycle after the acknowledging cycle, carrying the port's data and the fetched address. For a zero-filled fetch it pulses two cycles after the fetch is accepted.
- R9: The program counter advances by 2 when a word is delivered, wrapping from 0x1FFFFE to 0x000000, and holds while a fetch is outstanding.
- R10: When no fetch is outstanding, `irq_hi` loads 0x000008 and `irq_lo` loads 0x000018 (`irq_hi` wins if both are high), and `jmp_en` loads `jmp_addr` with bit 0 cleared. Any of these takes priority over starting a fetch. The same requests made while a fetch is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the memory mode |
| cfg_mode | input | 2 | Mode code (two low bits of the configuration byte) |
| fetch_en | input | 1 | Core requests instruction words |
| irq_hi | input | 1 | High-priority vector load request |
| irq_lo | input | 1 | Low-priority vector load request |
| jmp_en | input | 1 | Branch load request |
| jmp_addr | input | 21 | Branch target byte address |
| int_req | output | 1 | On-chip flash read request |
| int_addr | output | 21 | On-chip flash byte address |
| int_ack | input | 1 | On-chip flash acknowledge, data valid |
| int_rdata | input | 16 | On-chip flash read data |
| ext_req | output | 1 | External bus read request |
| ext_addr | output | 21 | External bus byte address |
| ext_ack | input | 1 | External bus acknowledge, data valid |
| ext_rdata | input | 16 | External bus read data |
| instr_valid | output | 1 | One-cycle pulse: fetched word valid |
| instr_word | output | 16 | Fetched instruction word |
| instr_addr | output | 21 | Byte address of the fetched word |
| pc_out | output | 21 | Current program counter |

## Verification
A wrong latched route shows up within one cycle of acceptance as the wrong strobe, or as a strobe where a zero fill was due. A latched address that disagrees with the program counter shows on the port address in that same cycle. A counter that fails to hold or advance shows on `pc_out` immediately and on the next fetch's address. An FSM that does not return to idle leaves `instr_valid` silent, which the bench sees within a few cycles of the expected acknowledge. The mode and flash-size boundaries are probed on both sides of each limit, so an off-by-one decode swaps the port at exactly one address.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    MODE_EXT    = 2'b00,
    MODE_XTD    = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_ONCHIP = 2'b11
  } mem_mode_e;

  typedef enum logic [1:0] {
    RT_INT  = 2'd0,
    RT_EXT  = 2'd1,
    RT_ZERO = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_ZERO = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/fr_route_dec.sv
module fr_route_dec
  import fr_pkg::*;
#(
  parameter int                AW        = ADDR_W,
  parameter logic [AW-1:0]     FLASH_TOP = AW'(32'h0FFFF),
  parameter logic [AW-1:0]     BOOT_TOP  = AW'(32'h001FF)
) (
  input  mem_mode_e      mode,
  input  logic [AW-1:0]  addr,
  output route_e         route
);
  logic in_flash;
  logic in_boot;

  always_comb begin
    in_flash = (addr <= FLASH_TOP);
    in_boot  = (addr <= BOOT_TOP);
    unique case (mode)
      MODE_EXT:    route = RT_EXT;
      MODE_XTD:    route = in_flash ? RT_INT : RT_EXT;
      MODE_BOOT:   route = in_boot  ? RT_INT : RT_EXT;
      MODE_ONCHIP: route = in_flash ? RT_INT : RT_ZERO;
      default:     route = RT_ZERO;
    endcase
  end
endmodule

// File: rtl/fr_pc.sv
module fr_pc
  import fr_pkg::*;
#(
  parameter int            AW     = ADDR_W,
  parameter logic [AW-1:0] RST_VEC = '0,
  parameter logic [AW-1:0] HI_VEC  = AW'(32'h08),
  parameter logic [AW-1:0] LO_VEC  = AW'(32'h18)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          irq_hi,
  input  logic          irq_lo,
  input  logic          jmp_en,
  input  logic [AW-1:0] jmp_addr,
  input  logic          adv,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP  = AW'(2);
  localparam logic [AW-1:0] ALIGN = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_n;
  logic          pc_en;

  always_comb begin
    pc_n  = pc_q;
    pc_en = 1'b0;
    if (idle && irq_hi) begin
      pc_n  = HI_VEC;
      pc_en = 1'b1;
    end else if (idle && irq_lo) begin
      pc_n  = LO_VEC;
      pc_en = 1'b1;
    end else if (idle && jmp_en) begin
      pc_n  = jmp_addr & ALIGN;
      pc_en = 1'b1;
    end else if (adv) begin
      pc_n  = pc_q + STEP;
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RST_VEC;
    else if (pc_en) pc_q <= pc_n;
  end

  assign pc = pc_q;

  p_vec_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq_hi) |=> (pc_q == HI_VEC));

  p_vec_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !irq_hi && irq_lo) |=> (pc_q == LO_VEC));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !adv) |=> $stable(pc_q));

  p_pc_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);
endmodule

// File: rtl/fr_fetch_fsm.sv
module fr_fetch_fsm
  import fr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          redirect,
  input  logic [AW-1:0] pc,
  input  route_e        route_in,
  output logic          idle,
  output logic          adv,
  output logic          int_req,
  output logic [AW-1:0] int_addr,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata,
  output logic          ext_req,
  output logic [AW-1:0] ext_addr,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata,
  output logic          instr_valid,
  output logic [DW-1:0] instr_word,
  output logic [AW-1:0] instr_addr
);
  fetch_st_e     st_q,    st_n;
  route_e        route_q, route_n;
  logic [AW-1:0] addr_q,  addr_n;
  logic          vld_q,   vld_n;
  logic [DW-1:0] word_q,  word_n;
  logic [AW-1:0] iadr_q,  iadr_n;
  logic          ack_sel;
  logic [DW-1:0] data_sel;
  logic          cap_en;

  always_comb begin
    ack_sel  = (route_q == RT_INT) ? int_ack   : ext_ack;
    data_sel = (route_q == RT_INT) ? int_rdata : ext_rdata;
    idle     = (st_q == S_IDLE);
    adv      = ((st_q == S_WAIT) && ack_sel) || (st_q == S_ZERO);
  end

  always_comb begin
    st_n    = st_q;
    route_n = route_q;
    addr_n  = addr_q;
    vld_n   = 1'b0;
    word_n  = word_q;
    iadr_n  = iadr_q;
    cap_en  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (fetch_en && !redirect) begin
          route_n = route_in;
          addr_n  = pc;
          cap_en  = 1'b1;
          st_n    = (route_in == RT_ZERO) ? S_ZERO : S_WAIT;
        end
      end
      S_WAIT: begin
        if (ack_sel) begin
          vld_n  = 1'b1;
          word_n = data_sel;
          iadr_n = addr_q;
          st_n   = S_IDLE;
        end
      end
      S_ZERO: begin
        vld_n  = 1'b1;
        word_n = '0;
        iadr_n = addr_q;
        st_n   = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_ZERO;
      addr_q  <= '0;
    end else if (cap_en) begin
      route_q <= route_n;
      addr_q  <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      iadr_q <= '0;
    end else if (vld_n) begin
      word_q <= word_n;
      iadr_q <= iadr_n;
    end
  end

  assign int_req     = (st_q == S_WAIT) && (route_q == RT_INT);
  assign ext_req     = (st_q == S_WAIT) && (route_q == RT_EXT);
  assign int_addr    = addr_q;
  assign ext_addr    = addr_q;
  assign instr_valid = vld_q;
  assign instr_word  = word_q;
  assign instr_addr  = iadr_q;

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_req && ext_req));

  p_int_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable(int_addr)));

  p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

  p_ack_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_req && int_ack) || (ext_req && ext_ack)) |=> instr_valid);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);

  p_zero_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ZERO) |=> (instr_valid && (instr_word == '0) && !int_req && !ext_req));
endmodule

// File: rtl/fetch_route_top.sv
module fetch_route_top
  import fr_pkg::*;
#(
  parameter int FLASH_KB = 64,
  parameter int AW       = ADDR_W,
  parameter int DW       = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          fetch_en,
  input  logic          irq_hi,
  input  logic          irq_lo,
  input  logic          jmp_en,
  input  logic [AW-1:0] jmp_addr,
  output logic          int_req,
  output logic [AW-1:0] int_addr,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata,
  output logic          ext_req,
  output logic [AW-1:0] ext_addr,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata,
  output logic          instr_valid,
  output logic [DW-1:0] instr_word,
  output logic [AW-1:0] instr_addr,
  output logic [AW-1:0] pc_out
);
  localparam logic [AW-1:0] FLASH_TOP = AW'(FLASH_KB * 1024 - 1);
  localparam logic [AW-1:0] BOOT_TOP  = AW'(32'h001FF);

  mem_mode_e     mode_q, mode_n;
  route_e        route;
  logic          idle;
  logic          adv;
  logic          redirect;
  logic [AW-1:0] pc;

  always_comb begin
    mode_n = cfg_we ? mem_mode_e'(cfg_mode) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ONCHIP;
    else        mode_q <= mode_n;
  end

  assign redirect = irq_hi || irq_lo || jmp_en;

  fr_route_dec #(
    .AW(AW), .FLASH_TOP(FLASH_TOP), .BOOT_TOP(BOOT_TOP)
  ) u_dec (
    .mode (mode_q),
    .addr (pc),
    .route(route)
  );

  fr_pc #(.AW(AW)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (idle),
    .irq_hi  (irq_hi),
    .irq_lo  (irq_lo),
    .jmp_en  (jmp_en),
    .jmp_addr(jmp_addr),
    .adv     (adv),
    .pc      (pc)
  );

  fr_fetch_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en   (fetch_en),
    .redirect   (redirect),
    .pc         (pc),
    .route_in   (route),
    .idle       (idle),
    .adv        (adv),
    .int_req    (int_req),
    .int_addr   (int_addr),
    .int_ack    (int_ack),
    .int_rdata  (int_rdata),
    .ext_req    (ext_req),
    .ext_addr   (ext_addr),
    .ext_ack    (ext_ack),
    .ext_rdata  (ext_rdata),
    .instr_valid(instr_valid),
    .instr_word (instr_word),
    .instr_addr (instr_addr)
  );

  assign pc_out = pc;

  p_ext_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && fetch_en && !redirect && (mode_q == MODE_EXT)) |=> ext_req);

  p_boot_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && fetch_en && !redirect && (mode_q == MODE_BOOT) && (pc <= BOOT_TOP)) |=> int_req);

  p_req_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && fetch_en && !redirect) |=> (int_addr == $past(pc)));
endmodule

// File: tb/fetch_route_top_bench.sv
module fetch_route_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int FKB = 64;
  localparam int RT_I = 0;
  localparam int RT_E = 1;
  localparam int RT_Z = 2;
  localparam int NVEC = 12;
  // {mode[1:0], byte address[20:0], expected route[1:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {2'b00, 21'h000000, 2'd1},
    {2'b00, 21'h1FFFFE, 2'd1},
    {2'b10, 21'h0001FE, 2'd0},
    {2'b10, 21'h000200, 2'd1},
    {2'b10, 21'h000000, 2'd0},
    {2'b11, 21'h00FFFE, 2'd0},
    {2'b11, 21'h010000, 2'd2},
    {2'b11, 21'h1FFFFE, 2'd2},
    {2'b01, 21'h00FFFE, 2'd0},
    {2'b01, 21'h010000, 2'd1},
    {2'b01, 21'h000000, 2'd0},
    {2'b01, 21'h1FFFFE, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic fetch_en = 1'b0;
  logic irq_hi = 1'b0;
  logic irq_lo = 1'b0;
  logic jmp_en = 1'b0;
  logic [AW-1:0] jmp_addr = '0;
  logic int_req, ext_req, instr_valid;
  logic [AW-1:0] int_addr, ext_addr, instr_addr, pc_out;
  logic int_ack = 1'b0;
  logic ext_ack = 1'b0;
  logic [DW-1:0] int_rdata = '0;
  logic [DW-1:0] ext_rdata = '0;
  logic [DW-1:0] instr_word;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int icnt = 0;
  int ecnt = 0;
  int cyc = 0;

  fetch_route_top #(.FLASH_KB(FKB)) u_fetch_route_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .fetch_en(fetch_en), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .jmp_en(jmp_en), .jmp_addr(jmp_addr),
    .int_req(int_req), .int_addr(int_addr), .int_ack(int_ack), .int_rdata(int_rdata),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_rdata(ext_rdata),
    .instr_valid(instr_valid), .instr_word(instr_word), .instr_addr(instr_addr),
    .pc_out(pc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] iword(input logic [AW-1:0] a);
    return a[16:1] ^ 16'h1234;
  endfunction

  function automatic logic [DW-1:0] eword(input logic [AW-1:0] a);
    return a[16:1] ^ {11'h5A3, a[20:16]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory port models, driven away from the active edge
  always @(negedge clk) begin
    if (int_req) begin
      int_ack   = (icnt >= lat);
      int_rdata = iword(int_addr);
      icnt++;
    end else begin
      int_ack = 1'b0;
      icnt = 0;
    end
    if (ext_req) begin
      ext_ack   = (ecnt >= lat);
      ext_rdata = eword(ext_addr);
      ecnt++;
    end else begin
      ext_ack = 1'b0;
      ecnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic jump(input logic [AW-1:0] a);
    @(negedge clk);
    jmp_en = 1'b1;
    jmp_addr = a;
    @(negedge clk);
    jmp_en = 1'b0;
  endtask

  // one fetch; returns route seen, port address, delivered word, address, cycle count
  task automatic fetch(input int l, input bit poke,
                       output int rt, output logic [AW-1:0] padr,
                       output logic [DW-1:0] w, output logic [AW-1:0] wadr,
                       output int n, output bit both, output bit pc_moved);
    logic [AW-1:0] pc0;
    lat = l;
    rt = RT_Z;
    padr = '0;
    both = 1'b0;
    pc_moved = 1'b0;
    w = '1;
    wadr = '1;
    n = 0;
    @(negedge clk);
    pc0 = pc_out;
    fetch_en = 1'b1;
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (poke && n == 1) irq_hi = 1'b1;
      if (poke && n == 2) irq_hi = 1'b0;
      if (int_req && ext_req) both = 1'b1;
      if (int_req) begin rt = RT_I; padr = int_addr; end
      if (ext_req) begin rt = RT_E; padr = ext_addr; end
      if (instr_valid) begin
        w = instr_word;
        wadr = instr_addr;
        break;
      end
      if (pc_out != pc0) pc_moved = 1'b1;
    end
    fetch_en = 1'b0;
    irq_hi = 1'b0;
  endtask

  initial begin
    int rt, n;
    bit both, moved;
    logic [AW-1:0] padr, wadr;
    logic [DW-1:0] w;
    logic [DW-1:0] ew;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(pc_out == '0, "R1 pc", 32'(pc_out), 0);
    check(!int_req && !ext_req, "R1 strobes", {30'b0, int_req, ext_req}, 0);
    check(!instr_valid, "R1 valid", 32'(instr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 default mode on-chip-only: above flash top is zero fill
    jump(21'h010000);
    fetch(0, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_Z && w == 16'h0, "R1 default mode", 32'(rt), RT_Z);

    // table walk: R3 R4 R5 R6 routing
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] m;
      logic [AW-1:0] a;
      int er;
      m  = VEC[i][24:23];
      a  = VEC[i][22:2];
      er = int'(VEC[i][1:0]);
      set_mode(m);
      jump(a);
      fetch(i % 3, 0, rt, padr, w, wadr, n, both, moved);
      ew = (er == RT_I) ? iword(a) : (er == RT_E) ? eword(a) : 16'h0;
      check(rt == er, "R3/R4/R5/R6 route", 32'(rt), 32'(er));
      check(w == ew, "R5 word", 32'(w), 32'(ew));
      check(er == RT_Z || padr == a, "R7 port address", 32'(padr), 32'(a));
      check(wadr == a, "R8 word address", 32'(wadr), 32'(a));
      check(!both, "R7 one strobe", 32'(both), 0);
      check(n == ((er == RT_Z) ? 2 : (i % 3) + 2), "R8 latency", 32'(n),
            32'((er == RT_Z) ? 2 : (i % 3) + 2));
      check(!moved, "R9 hold", 32'(moved), 0);
      check(pc_out == a + 21'd2, "R9 advance", 32'(pc_out), 32'(a + 21'd2));
    end

    // R2: mode write changes routing of the same address
    set_mode(2'b10);
    jump(21'h000400);
    fetch(0, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_E, "R2 boot mode", 32'(rt), RT_E);
    set_mode(2'b11);
    jump(21'h000400);
    fetch(0, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_I, "R2 on-chip mode", 32'(rt), RT_I);

    // R6 seamless switch in extended mode across the flash top
    set_mode(2'b01);
    jump(21'h00FFFC);
    fetch(1, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_I && padr == 21'h00FFFC, "R6 seq0", 32'(padr), 32'h0FFFC);
    fetch(0, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_I && padr == 21'h00FFFE, "R6 seq1", 32'(padr), 32'h0FFFE);
    fetch(2, 0, rt, padr, w, wadr, n, both, moved);
    check(rt == RT_E && padr == 21'h010000, "R6 seq2", 32'(padr), 32'h10000);
    check(w == eword(21'h010000), "R8 ext data", 32'(w), 32'(eword(21'h010000)));

    // R9 wrap at the top of the space
    set_mode(2'b00);
    jump(21'h1FFFFE);
    fetch(0, 0, rt, padr, w, wadr, n, both, moved);
    check(pc_out == '0, "R9 wrap", 32'(pc_out), 0);

    // R10 vectors and priority
    @(negedge clk);
    irq_hi = 1'b1;
    irq_lo = 1'b1;
    @(negedge clk);
    irq_hi = 1'b0;
    irq_lo = 1'b0;
    check(pc_out == 21'h000008, "R10 hi wins", 32'(pc_out), 8);
    @(negedge clk);
    irq_lo = 1'b1;
    @(negedge clk);
    irq_lo = 1'b0;
    check(pc_out == 21'h000018, "R10 lo vector", 32'(pc_out), 32'h18);
    jump(21'h000123);
    check(pc_out == 21'h000122, "R10 jump aligned", 32'(pc_out), 32'h122);

    // R10 redirect beats fetch in the same cycle
    @(negedge clk);
    fetch_en = 1'b1;
    irq_hi = 1'b1;
    @(negedge clk);
    check(!int_req && !ext_req && pc_out == 21'h000008, "R10 redirect priority",
          32'(pc_out), 8);
    fetch_en = 1'b0;
    irq_hi = 1'b0;
    // the fetch may start on the cycle fetch_en dropped? no: dropped before the edge
    @(negedge clk);
    check(!int_req && !ext_req, "R10 no fetch after redirect", {30'b0, int_req, ext_req}, 0);

    // R10 vector request while a fetch is outstanding is ignored
    jump(21'h000040);
    fetch(3, 1, rt, padr, w, wadr, n, both, moved);
    check(padr == 21'h000040 && pc_out == 21'h000042, "R10 ignored while busy",
          32'(pc_out), 32'h42);
    check(!moved, "R9 hold with irq", 32'(moved), 0);

    // R8 valid is a single-cycle pulse
    @(negedge clk);
    check(!instr_valid, "R8 pulse", 32'(instr_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule